// File: doc/BRIEF.md
# Load/Store Data Alignment Unit

This block sits in the memory stage of a 32-bit load/store pipeline. It forms the effective address from a base register value and a sign-extended immediate. For stores, it steers the least significant byte or halfword of the source register onto the correct byte lanes and drives a byte-enable mask. For loads, it turns a returned memory word into the value written back to the destination register. The load forms are signed and unsigned byte, signed and unsigned halfword, full word, and a pair of unaligned-word loads. The unaligned pair shifts the addressed bytes to one end of the register and merges them with the register's current contents.

Byte order is big-endian. Byte offset 0 within a word is bits [31:24], and byte offset 3 is bits [7:0]. Misaligned halfword and word accesses raise an alignment error output. The load result is captured in a register on the clock edge that follows valid memory data. The address, store lanes and error flag are combinational.

Top module: `lsa_align_unit`

## Requirements
- R1: `addr_o` equals `base_i + offset_i`, modulo 2^32, for every operation code. The byte offset k is `addr_o[1:0]`.
- R2: Code 0 is the signed byte load and code 1 is the unsigned byte load. Both take memory bits [31-8k:24-8k]. Code 0 sign-extends that byte to 32 bits and code 1 zero-extends it.
- R3: Code 2 is the signed halfword load and code 3 is the unsigned halfword load. When `addr_o[1]` is 0 they take bits [31:16], and when it is 1 they take bits [15:0]. Code 2 sign-extends the halfword and code 3 zero-extends it.
- R4: Code 4 is the word load. It returns the memory word unchanged.
- R5: Code 5 is the left unaligned load. At offset k, memory bytes k..3 fill the result from bits [31:24] downward, and the low k bytes of `rt_i` are kept.
- R6: Code 6 is the right unaligned load. At offset k, memory bytes 0..k fill the low k+1 bytes of the result, and the upper 3-k bytes of `rt_i` are kept.
- R7: Code 8 is the byte store. `st_data_o` carries `rt_i[7:0]` in all four lanes. `st_be_o` has only bit 3-k set, where bit i enables bits [8i+7:8i].
- R8: Code 9 is the halfword store. `st_data_o` carries `rt_i[15:0]` in both halves. `st_be_o` is 4'b1100 when `addr_o[1]` is 0 and 4'b0011 when it is 1. It is 4'b0000 when `addr_o[0]` is 1.
- R9: `align_err_o` is high for codes 2, 3 and 9 when `addr_o[0]` is 1, and for code 4 when `addr_o[1:0]` is not 0. It is low for every other code and offset, including codes 5 and 6.
- R10: A code in the range 0 to 6 with `mem_valid_i` high and no alignment error updates `ld_result_o` at the next rising edge and raises `ld_valid_o` for one cycle. In every other case `ld_result_o` holds its value and `ld_valid_o` is low.
- R11: Codes other than 8 and 9 drive `st_be_o` and `st_data_o` to zero. Codes 7 and 10 to 15 have no effect on any output except `addr_o`.
- R12: A synchronous active-low reset clears `ld_result_o` and `ld_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 4 | Operation code |
| base_i | input | 32 | Base register value |
| offset_i | input | 32 | Sign-extended immediate offset |
| rt_i | input | 32 | Current value of the source/destination register |
| mem_rdata_i | input | 32 | Word returned by memory |
| mem_valid_i | input | 1 | Memory data valid this cycle |
| addr_o | output | 32 | Effective address |
| st_data_o | output | 32 | Store data, replicated across lanes |
| st_be_o | output | 4 | Store byte enables, bit i covers bits [8i+7:8i] |
| align_err_o | output | 1 | Misaligned halfword or word access |
| ld_result_o | output | 32 | Registered load result |
| ld_valid_o | output | 1 | Load result updated on the last edge |

## Verification
The bench builds the unit with its default 32-bit data width, which gives four byte lanes and two address bits of offset. At that size every operation code can be swept against every byte offset with several register and memory patterns, including bytes whose top bit is set. This covers every merge boundary of the unaligned pair and every misaligned case. Base and offset values are chosen at random, with the offset trimmed to reach each target alignment, so address carries through negative offsets are exercised as well.

// File: rtl/lsa_pkg.sv
// Package: operation codes and helpers shared by the alignment unit.
// Assumes a 4-bit operation code; codes not listed are no-operations.
package lsa_pkg;

    typedef enum logic [3:0] {
        LD_BYTE_S = 4'd0,
        LD_BYTE_U = 4'd1,
        LD_HALF_S = 4'd2,
        LD_HALF_U = 4'd3,
        LD_WORD   = 4'd4,
        LD_LEFT   = 4'd5,
        LD_RIGHT  = 4'd6,
        ST_BYTE   = 4'd8,
        ST_HALF   = 4'd9
    } lsa_op_e;

    // True for every load form, including the unaligned pair.
    function automatic logic is_load(input logic [3:0] op);
        return op <= LD_RIGHT;
    endfunction

    // True for the two store forms.
    function automatic logic is_store(input logic [3:0] op);
        return (op == ST_BYTE) || (op == ST_HALF);
    endfunction

endpackage

// File: rtl/lsa_addr_gen.sv
// Module: effective address adder.
// Adds base and an already sign-extended offset; exposes the byte offset
// within a word. Assumes DATA_W is a power of two multiple of 8.
module lsa_addr_gen #(
    parameter int DATA_W = 32,
    localparam int NBYTES = DATA_W / 8,
    localparam int OFS_W  = $clog2(NBYTES)
) (
    input  logic [DATA_W-1:0] base_i,
    input  logic [DATA_W-1:0] offset_i,
    output logic [DATA_W-1:0] addr_o,
    output logic [OFS_W-1:0]  ofs_o
);

    // Wrap-around sum; identical for every operation.
    always_comb begin
        addr_o = base_i + offset_i;
        ofs_o  = addr_o[OFS_W-1:0];
    end

endmodule

// File: rtl/lsa_align_check.sv
// Module: alignment checker.
// Flags halfword accesses with an odd address and word loads that are not
// on a word boundary. Byte accesses and the unaligned pair never fault.
module lsa_align_check #(
    parameter int NBYTES = 4,
    localparam int OFS_W = $clog2(NBYTES)
) (
    input  logic [3:0]       op_i,
    input  logic [OFS_W-1:0] ofs_i,
    output logic             err_o
);
    import lsa_pkg::*;

    // Decode the required alignment from the operation code.
    always_comb begin
        case (op_i)
            LD_HALF_S, LD_HALF_U, ST_HALF: err_o = ofs_i[0];
            LD_WORD:                       err_o = (ofs_i != '0);
            default:                       err_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/lsa_store_lanes.sv
// Module: store lane steering.
// Replicates the store byte or halfword across the lanes and enables the
// lanes of the addressed item. Big-endian: byte offset k sits in lane
// NBYTES-1-k. A faulting store enables no lane.
module lsa_store_lanes #(
    parameter int DATA_W = 32,
    localparam int NBYTES = DATA_W / 8,
    localparam int HALVES = NBYTES / 2,
    localparam int OFS_W  = $clog2(NBYTES)
) (
    input  logic [3:0]        op_i,
    input  logic [OFS_W-1:0]  ofs_i,
    input  logic              err_i,
    input  logic [15:0]       src_i,
    output logic [DATA_W-1:0] data_o,
    output logic [NBYTES-1:0] be_o
);
    import lsa_pkg::*;

    logic [NBYTES-1:0] byte_hit;
    logic [NBYTES-1:0] half_hit;

    // Per-lane match against the addressed byte and halfword.
    for (genvar i = 0; i < NBYTES; i++) begin : g_lane
        localparam int BE_IDX = NBYTES - 1 - i;
        assign byte_hit[i] = (int'(ofs_i) == BE_IDX);
        assign half_hit[i] = (int'(ofs_i[OFS_W-1:1]) == BE_IDX / 2);
    end

    // Select data replication and lane mask by operation.
    always_comb begin
        case (op_i)
            ST_BYTE: begin
                data_o = {NBYTES{src_i[7:0]}};
                be_o   = byte_hit;
            end
            ST_HALF: begin
                data_o = {HALVES{src_i}};
                be_o   = err_i ? '0 : half_hit;
            end
            default: begin
                data_o = '0;
                be_o   = '0;
            end
        endcase
    end

endmodule

// File: rtl/lsa_load_extract.sv
// Module: load data extraction and merge.
// Picks the addressed byte or halfword out of a big-endian memory word,
// extends it, or shifts the word for the unaligned pair and merges it with
// the old register value. Purely combinational.
module lsa_load_extract #(
    parameter int DATA_W = 32,
    localparam int NBYTES = DATA_W / 8,
    localparam int HALVES = NBYTES / 2,
    localparam int OFS_W  = $clog2(NBYTES),
    localparam int SHW    = $clog2(DATA_W)
) (
    input  logic [3:0]        op_i,
    input  logic [OFS_W-1:0]  ofs_i,
    input  logic [DATA_W-1:0] mem_i,
    input  logic [DATA_W-1:0] rt_i,
    output logic [DATA_W-1:0] result_o
);
    import lsa_pkg::*;

    logic [SHW-1:0]    sh_up;
    logic [SHW-1:0]    sh_down;
    logic [SHW-1:0]    sh_half;
    logic [7:0]        byte_v;
    logic [15:0]       half_v;
    logic [DATA_W-1:0] keep_up;
    logic [DATA_W-1:0] keep_down;
    logic [DATA_W-1:0] left_v;
    logic [DATA_W-1:0] right_v;
    logic              ext_b;
    logic              ext_h;

    // Shift distances derived from the byte offset.
    always_comb begin
        sh_up   = SHW'(8 * int'(ofs_i));
        sh_down = SHW'(8 * (NBYTES - 1 - int'(ofs_i)));
        sh_half = SHW'(16 * (HALVES - 1 - int'(ofs_i[OFS_W-1:1])));
    end

    // Extract byte and halfword, and build the unaligned merges.
    always_comb begin
        byte_v    = 8'(mem_i >> sh_down);
        half_v    = 16'(mem_i >> sh_half);
        keep_up   = {DATA_W{1'b1}} << sh_up;
        keep_down = {DATA_W{1'b1}} >> sh_down;
        left_v    = (mem_i << sh_up) | (rt_i & ~keep_up);
        right_v   = (mem_i >> sh_down) | (rt_i & ~keep_down);
        ext_b     = (op_i == LD_BYTE_S) & byte_v[7];
        ext_h     = (op_i == LD_HALF_S) & half_v[15];
    end

    // Final selection by load form.
    always_comb begin
        case (op_i)
            LD_BYTE_S, LD_BYTE_U: result_o = {{(DATA_W-8){ext_b}}, byte_v};
            LD_HALF_S, LD_HALF_U: result_o = {{(DATA_W-16){ext_h}}, half_v};
            LD_WORD:              result_o = mem_i;
            LD_LEFT:              result_o = left_v;
            LD_RIGHT:             result_o = right_v;
            default:              result_o = rt_i;
        endcase
    end

endmodule

// File: rtl/lsa_align_unit.sv
// Module: load/store data alignment unit (top).
// Forms the effective address, steers store data onto byte lanes and
// registers the aligned load result one edge after valid memory data.
// Assumes big-endian byte order and a synchronous active-low reset.
module lsa_align_unit #(
    parameter int DATA_W = 32,
    localparam int NBYTES = DATA_W / 8,
    localparam int OFS_W  = $clog2(NBYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] base_i,
    input  logic [DATA_W-1:0] offset_i,
    input  logic [DATA_W-1:0] rt_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              mem_valid_i,
    output logic [DATA_W-1:0] addr_o,
    output logic [DATA_W-1:0] st_data_o,
    output logic [NBYTES-1:0] st_be_o,
    output logic              align_err_o,
    output logic [DATA_W-1:0] ld_result_o,
    output logic              ld_valid_o
);

    logic [OFS_W-1:0]  ofs;
    logic [DATA_W-1:0] ld_next;
    logic              take;

    lsa_addr_gen #(.DATA_W(DATA_W)) u_addr (
        .base_i   (base_i),
        .offset_i (offset_i),
        .addr_o   (addr_o),
        .ofs_o    (ofs)
    );

    lsa_align_check #(.NBYTES(NBYTES)) u_chk_align (
        .op_i  (op_i),
        .ofs_i (ofs),
        .err_o (align_err_o)
    );

    lsa_store_lanes #(.DATA_W(DATA_W)) u_store (
        .op_i   (op_i),
        .ofs_i  (ofs),
        .err_i  (align_err_o),
        .src_i  (rt_i[15:0]),
        .data_o (st_data_o),
        .be_o   (st_be_o)
    );

    lsa_load_extract #(.DATA_W(DATA_W)) u_load (
        .op_i     (op_i),
        .ofs_i    (ofs),
        .mem_i    (mem_rdata_i),
        .rt_i     (rt_i),
        .result_o (ld_next)
    );

    // Capture only well-aligned loads with data present.
    assign take = mem_valid_i && lsa_pkg::is_load(op_i) && !align_err_o;

    // Load result register with synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_result_o <= '0;
            ld_valid_o  <= 1'b0;
        end else begin
            ld_valid_o <= take;
            if (take) begin
                ld_result_o <= ld_next;
            end
        end
    end

endmodule

// File: rtl/lsa_align_unit_chk.sv
// Module: property checker bound to the alignment unit.
// Observes ports only; relates lane enables, faults and the result register.
module lsa_align_unit_chk #(
    parameter int DATA_W = 32,
    localparam int NBYTES = DATA_W / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        op_i,
    input logic              mem_valid_i,
    input logic [NBYTES-1:0] st_be_o,
    input logic              align_err_o,
    input logic [DATA_W-1:0] ld_result_o,
    input logic              ld_valid_o
);
    import lsa_pkg::*;

    AST_BYTE_STORE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == ST_BYTE) |-> ($countones(st_be_o) == 1)); // R7

    AST_FAULT_NO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        align_err_o |-> (st_be_o == '0)); // R8

    AST_NONSTORE_NO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        !((op_i == ST_BYTE) || (op_i == ST_HALF)) |-> (st_be_o == '0)); // R11

    AST_PAIR_NEVER_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i == LD_LEFT) || (op_i == LD_RIGHT)) |-> !align_err_o); // R9

    AST_VALID_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid_o |-> $past(mem_valid_i && !align_err_o)); // R10

    AST_HOLD_WITHOUT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_valid_i |=> $stable(ld_result_o)); // R10

endmodule

bind lsa_align_unit lsa_align_unit_chk #(.DATA_W(DATA_W)) u_props (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_i        (op_i),
    .mem_valid_i (mem_valid_i),
    .st_be_o     (st_be_o),
    .align_err_o (align_err_o),
    .ld_result_o (ld_result_o),
    .ld_valid_o  (ld_valid_o)
);

// File: tb/lsa_align_unit_test.sv
// Bench: sweeps every operation code over every byte offset with several
// data patterns; expected values come from a byte-array model.
module lsa_align_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_i = '0;
    logic [31:0] base_i = '0;
    logic [31:0] offset_i = '0;
    logic [31:0] rt_i = '0;
    logic [31:0] mem_rdata_i = '0;
    logic        mem_valid_i = 1'b0;
    logic [31:0] addr_o;
    logic [31:0] st_data_o;
    logic [3:0]  st_be_o;
    logic        align_err_o;
    logic [31:0] ld_result_o;
    logic        ld_valid_o;

    int          checks = 0;
    int          errors = 0;
    logic [31:0] exp_res = '0;
    logic [31:0] rng = 32'h1234_5678;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    lsa_align_unit uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_i        (op_i),
        .base_i      (base_i),
        .offset_i    (offset_i),
        .rt_i        (rt_i),
        .mem_rdata_i (mem_rdata_i),
        .mem_valid_i (mem_valid_i),
        .addr_o      (addr_o),
        .st_data_o   (st_data_o),
        .st_be_o     (st_be_o),
        .align_err_o (align_err_o),
        .ld_result_o (ld_result_o),
        .ld_valid_o  (ld_valid_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] next_rand();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return rng;
    endfunction

    // Big-endian byte j of a word.
    function automatic logic [7:0] bget(input logic [31:0] w, input int j);
        return w[31 - 8*j -: 8];
    endfunction

    task automatic run_txn(input logic [3:0] op, input logic [31:0] base,
                           input logic [31:0] off, input logic [31:0] rt,
                           input logic [31:0] mem, input logic mv);
        logic [31:0] addr;
        int          k;
        logic        e_err;
        logic [3:0]  e_be;
        logic [31:0] e_data;
        logic [31:0] e_ld;
        logic [7:0]  b;
        logic [15:0] h;
        logic        is_ld;
        logic        e_valid;
        addr  = base + off;
        k     = int'(addr[1:0]);
        is_ld = (op <= 4'd6);
        // R9: fault rules.
        case (op)
            4'd2, 4'd3, 4'd9: e_err = addr[0];
            4'd4:             e_err = (k != 0);
            default:          e_err = 1'b0;
        endcase
        // R7, R8, R11: store lanes.
        case (op)
            4'd8: begin e_data = {4{rt[7:0]}}; e_be = 4'b0001 << (3 - k); end
            4'd9: begin
                e_data = {2{rt[15:0]}};
                e_be   = e_err ? 4'b0000 : (addr[1] ? 4'b0011 : 4'b1100);
            end
            default: begin e_data = '0; e_be = '0; end
        endcase
        // R2 to R6: load model over big-endian bytes.
        b = bget(mem, k);
        h = addr[1] ? mem[15:0] : mem[31:16];
        e_ld = rt;
        case (op)
            4'd0: e_ld = {{24{b[7]}}, b};
            4'd1: e_ld = {24'h0, b};
            4'd2: e_ld = {{16{h[15]}}, h};
            4'd3: e_ld = {16'h0, h};
            4'd4: e_ld = mem;
            4'd5: for (int j = 0; j < 4; j++)
                      e_ld[31 - 8*j -: 8] = (j + k <= 3) ? bget(mem, j + k) : bget(rt, j);
            4'd6: for (int j = 0; j < 4; j++)
                      e_ld[31 - 8*j -: 8] = (j >= 3 - k) ? bget(mem, j - (3 - k)) : bget(rt, j);
            default: e_ld = rt;
        endcase
        e_valid = mv && is_ld && !e_err;

        @(negedge clk);
        op_i = op; base_i = base; offset_i = off; rt_i = rt;
        mem_rdata_i = mem; mem_valid_i = mv;
        #2;
        chk("R1 address", addr_o, addr);
        chk("R9 align error", {31'h0, align_err_o}, {31'h0, e_err});
        chk("R7/R8/R11 byte enables", {28'h0, st_be_o}, {28'h0, e_be});
        chk("R7/R8/R11 store data", st_data_o, e_data);
        @(negedge clk);
        if (e_valid) exp_res = e_ld;
        chk("R10 load valid", {31'h0, ld_valid_o}, {31'h0, e_valid});
        case (op)
            4'd0, 4'd1: chk("R2 byte load", ld_result_o, exp_res);
            4'd2, 4'd3: chk("R3 halfword load", ld_result_o, exp_res);
            4'd4:       chk("R4 word load", ld_result_o, exp_res);
            4'd5:       chk("R5 left unaligned load", ld_result_o, exp_res);
            4'd6:       chk("R6 right unaligned load", ld_result_o, exp_res);
            default:    chk("R11 no-op holds result", ld_result_o, exp_res);
        endcase
        mem_valid_i = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [3:0] ops [12];
        ops = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd8, 4'd9, 4'd7, 4'd12, 4'd15};
        repeat (3) @(negedge clk);
        chk("R12 reset result", ld_result_o, 32'h0);
        chk("R12 reset valid", {31'h0, ld_valid_o}, 32'h0);
        rst_n = 1'b1;
        foreach (ops[oi]) begin
            for (int k = 0; k < 4; k++) begin
                for (int p = 0; p < 6; p++) begin
                    logic [31:0] base = next_rand();
                    logic [31:0] off  = next_rand();
                    logic [31:0] rt   = next_rand();
                    logic [31:0] mem  = next_rand();
                    if (p == 0) begin mem = 32'h80FF_7F01; rt = 32'hA5C3_3C5A; end
                    if (p == 1) begin mem = 32'h7F01_80FE; rt = 32'h0123_4567; end
                    if (p == 2) off = 32'hFFFF_FF00 | off;
                    off = (off & 32'hFFFF_FFFC) | 32'((k - int'(base[1:0])) & 3);
                    run_txn(ops[oi], base, off, rt, mem, p != 5);
                end
            end
        end
        // R12: clear from a nonzero result.
        run_txn(4'd4, 32'h100, 32'h0, 32'h0, 32'hDEAD_BEEF, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R12 mid-run reset result", ld_result_o, 32'h0);
        chk("R12 mid-run reset valid", {31'h0, ld_valid_o}, 32'h0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule